// File: doc/BRIEF.md
# Memory-Mapped Character Display Port

This block sits on a simple processor bus and turns word writes into characters for a downstream character sink. It has two registers. The control register reports whether the port can take a new word and whether a word was lost. Software writes 32-bit words to the data register. When the low byte is a normal character, the port sends that byte to the sink with the current cursor position and then moves the cursor one column to the right. When the low byte is the line-feed code, the cursor goes to the start of the next row. When the low byte is the bell code, the word is a cursor move: the new row and column are packed in its upper bits.

After each accepted data word the port is busy for a while and its ready flag stays low. The busy time is either a fixed number of clock cycles or, in acknowledge mode, lasts until the sink confirms the character. Software must poll the ready flag before each write. A write made while the port is busy is dropped and recorded in a sticky flag.

The control sequencer is a two-state machine. ST_IDLE means ready is high. ST_BUSY means the port is waiting out a write. There are four transitions. ACCEPT goes from ST_IDLE to ST_BUSY on a data-register write. EXPIRE goes from ST_BUSY to ST_IDLE when the busy counter reaches its limit. ACK_DONE goes from ST_BUSY to ST_IDLE when the sink acknowledges a character in acknowledge mode. HOLD keeps the machine in ST_BUSY until one of those exit conditions is met.

Top module: `display_port`

## Requirements
- R1: The control register is at 0xFFFF0008 and the data register is at 0xFFFF000C. A read of the control register returns bit 0 = ready and bit 1 = overrun, with all other bits 0. A read of the data register, or of any other address, returns 0.
- R2: After reset, ready is 1, overrun is 0, the cursor is at row 0 and column 0, and chr_valid is 0.
- R3: A data write accepted while ready is 1 with an ordinary low byte (not 0x07 and not 0x0A) raises chr_valid for exactly one cycle, in the cycle after the write. In that cycle chr_code equals bits 7:0 of the word. chr_row and chr_col hold the cursor position as it was before the write. Bits 31:8 of the word have no effect.
- R4: After an ordinary character, the column increases by one, wrapping from 4095 to 0, and the row does not change.
- R5: A low byte of 0x0A produces no strobe. It sets the column to 0 and increases the row by one.
- R6: A low byte of 0x07 produces no strobe. It loads the row from bits 19:8 and the column from bits 31:20.
- R7: In counted mode, and in acknowledge mode for words that are not ordinary characters, ready reads 0 for exactly BUSY_CYCLES cycles after an accepted data write.
- R8: In acknowledge mode, ready stays 0 after an ordinary character until chr_ack is seen high during the busy period, and returns to 1 in the following cycle. chr_ack while ready is 1 has no effect.
- R9: A data write while ready is 0 is dropped: there is no strobe and the cursor does not change. It sets overrun, and overrun stays set.
- R10: A control write with bit 1 set clears overrun. A control write with bit 1 clear changes nothing. A write to any address other than the two registers has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Bus access valid this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 32 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational |
| chr_valid | output | 1 | One-cycle character strobe to the sink |
| chr_code | output | 8 | Character code |
| chr_row | output | 12 | Row at which the character is placed |
| chr_col | output | 12 | Column at which the character is placed |
| chr_ack | input | 1 | Sink acknowledge, used in acknowledge mode |

## Verification
The bench builds two copies of the block. The first, `uut`, uses BUSY_CYCLES=3 in counted mode. This keeps the busy window short, so the bench can count it exactly and can land a second write inside it to trigger an overrun. The second, `uut_ack`, uses BUSY_CYCLES=2 with acknowledge mode on. This lets the bench hold a character pending for many cycles without an acknowledge, and compare that against the counted busy time of line-feed words. Cursor moves near column 4095 bring the column wrap within reach in a few writes.

// File: rtl/disp_pkg.sv
package disp_pkg;
    localparam int          DW        = 32;
    localparam int          ROW_W     = 12;
    localparam int          COL_W     = 12;
    localparam int          ROW_LSB   = 8;
    localparam int          COL_LSB   = ROW_LSB + ROW_W;
    localparam logic [7:0]  CODE_BELL = 8'h07;
    localparam logic [7:0]  CODE_LF   = 8'h0A;
    localparam int          BIT_READY = 0;
    localparam int          BIT_OVR   = 1;

    typedef enum logic {ST_IDLE, ST_BUSY} port_state_t;
    typedef enum logic [1:0] {KIND_CHAR, KIND_LF, KIND_MOVE} word_kind_t;

    function automatic word_kind_t classify(input logic [7:0] low);
        if (low == CODE_BELL)    return KIND_MOVE;
        else if (low == CODE_LF) return KIND_LF;
        else                     return KIND_CHAR;
    endfunction
endpackage

// File: rtl/disp_regif.sv
module disp_regif
    import disp_pkg::*;
#(
    parameter logic [31:0] CTRL_ADDR = 32'hFFFF_0008,
    parameter logic [31:0] DATA_ADDR = 32'hFFFF_000C
) (
    input  logic          sel,
    input  logic          we,
    input  logic [31:0]   addr,
    input  logic          ready,
    input  logic          overrun,
    output logic          data_wr,
    output logic          ctrl_wr,
    output logic [DW-1:0] rdata
);
    logic hit_ctrl, hit_data;

    assign hit_ctrl = sel && (addr == CTRL_ADDR);
    assign hit_data = sel && (addr == DATA_ADDR);
    assign data_wr  = hit_data && we;
    assign ctrl_wr  = hit_ctrl && we;

    always_comb begin
        rdata = '0;
        if (hit_ctrl && !we) begin
            rdata[BIT_READY] = ready;
            rdata[BIT_OVR]   = overrun;
        end
    end
endmodule

// File: rtl/disp_cursor.sv
module disp_cursor
    import disp_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             step,
    input  word_kind_t       kind,
    input  logic [ROW_W-1:0] new_row,
    input  logic [COL_W-1:0] new_col,
    output logic [ROW_W-1:0] row,
    output logic [COL_W-1:0] col
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            row <= '0;
            col <= '0;
        end else if (step) begin
            unique case (kind)
                KIND_CHAR: col <= col + 1'b1;
                KIND_LF: begin
                    col <= '0;
                    row <= row + 1'b1;
                end
                KIND_MOVE: begin
                    row <= new_row;
                    col <= new_col;
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/disp_fsm.sv
module disp_fsm
    import disp_pkg::*;
#(
    parameter int BUSY_CYCLES = 4,
    parameter bit WAIT_ACK    = 1'b0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             data_wr,
    input  logic             ctrl_wr,
    input  logic [DW-1:0]    wdata,
    input  logic             chr_ack,
    input  logic [ROW_W-1:0] cur_row,
    input  logic [COL_W-1:0] cur_col,
    output logic             ready,
    output logic             overrun,
    output logic             accept,
    output word_kind_t       kind,
    output logic             chr_valid,
    output logic [7:0]       chr_code,
    output logic [ROW_W-1:0] chr_row,
    output logic [COL_W-1:0] chr_col
);
    localparam int              CNT_W     = $clog2(BUSY_CYCLES + 1);
    localparam logic [CNT_W-1:0] BUSY_LAST = CNT_W'(BUSY_CYCLES - 1);

    port_state_t      state, state_nx;
    logic [CNT_W-1:0] cnt;
    logic             hold_ack;
    logic             ack_mode;
    logic             release_now;

    generate
        if (WAIT_ACK) begin : g_ack_mode
            assign ack_mode = 1'b1;
        end else begin : g_count_mode
            assign ack_mode = 1'b0;
        end
    endgenerate

    assign kind        = classify(wdata[7:0]);
    assign ready       = (state == ST_IDLE);
    assign accept      = ready && data_wr;
    assign release_now = hold_ack ? chr_ack : (cnt == BUSY_LAST);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: if (data_wr)     state_nx = ST_BUSY;
            ST_BUSY: if (release_now) state_nx = ST_IDLE;
            default: state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt       <= '0;
            hold_ack  <= 1'b0;
            overrun   <= 1'b0;
            chr_valid <= 1'b0;
            chr_code  <= '0;
            chr_row   <= '0;
            chr_col   <= '0;
        end else begin
            cnt       <= (state == ST_IDLE) ? '0 : cnt + 1'b1;
            chr_valid <= accept && (kind == KIND_CHAR);
            if (accept) begin
                hold_ack <= ack_mode && (kind == KIND_CHAR);
                chr_code <= wdata[7:0];
                chr_row  <= cur_row;
                chr_col  <= cur_col;
            end
            if (data_wr && !ready)             overrun <= 1'b1;
            else if (ctrl_wr && wdata[BIT_OVR]) overrun <= 1'b0;
        end
    end
endmodule

// File: rtl/display_port.sv
module display_port
    import disp_pkg::*;
#(
    parameter logic [31:0] CTRL_ADDR   = 32'hFFFF_0008,
    parameter logic [31:0] DATA_ADDR   = 32'hFFFF_000C,
    parameter int          BUSY_CYCLES = 4,
    parameter bit          WAIT_ACK    = 1'b0
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        bus_sel,
    input  logic        bus_we,
    input  logic [31:0] bus_addr,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata,
    output logic        chr_valid,
    output logic [7:0]  chr_code,
    output logic [11:0] chr_row,
    output logic [11:0] chr_col,
    input  logic        chr_ack
);
    logic             ready, overrun, data_wr, ctrl_wr, accept;
    word_kind_t       kind;
    logic [ROW_W-1:0] cur_row;
    logic [COL_W-1:0] cur_col;

    disp_regif #(.CTRL_ADDR(CTRL_ADDR), .DATA_ADDR(DATA_ADDR)) u_regif (
        .sel(bus_sel), .we(bus_we), .addr(bus_addr),
        .ready(ready), .overrun(overrun),
        .data_wr(data_wr), .ctrl_wr(ctrl_wr), .rdata(bus_rdata)
    );

    disp_fsm #(.BUSY_CYCLES(BUSY_CYCLES), .WAIT_ACK(WAIT_ACK)) u_fsm (
        .clk(clk), .rst_n(rst_n), .data_wr(data_wr), .ctrl_wr(ctrl_wr),
        .wdata(bus_wdata), .chr_ack(chr_ack), .cur_row(cur_row), .cur_col(cur_col),
        .ready(ready), .overrun(overrun), .accept(accept), .kind(kind),
        .chr_valid(chr_valid), .chr_code(chr_code), .chr_row(chr_row), .chr_col(chr_col)
    );

    disp_cursor u_cursor (
        .clk(clk), .rst_n(rst_n), .step(accept), .kind(kind),
        .new_row(bus_wdata[COL_LSB-1:ROW_LSB]),
        .new_col(bus_wdata[DW-1:COL_LSB]),
        .row(cur_row), .col(cur_col)
    );
endmodule

// File: rtl/display_port_chk.sv
module display_port_chk #(
    parameter logic [31:0] CTRL_ADDR = 32'hFFFF_0008,
    parameter logic [31:0] DATA_ADDR = 32'hFFFF_000C
) (
    input logic        clk,
    input logic        rst_n,
    input logic        bus_sel,
    input logic        bus_we,
    input logic [31:0] bus_addr,
    input logic [31:0] bus_wdata,
    input logic [31:0] bus_rdata,
    input logic        chr_valid,
    input logic [7:0]  chr_code,
    input logic        ready,
    input logic        overrun
);
    logic wr_d, wr_c, rd_d, plain;
    assign wr_d  = bus_sel && bus_we && (bus_addr == DATA_ADDR);
    assign wr_c  = bus_sel && bus_we && (bus_addr == CTRL_ADDR);
    assign rd_d  = bus_sel && !bus_we && (bus_addr == DATA_ADDR);
    assign plain = (bus_wdata[7:0] != 8'h07) && (bus_wdata[7:0] != 8'h0A);

    AST_DATA_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n) rd_d |-> bus_rdata == 32'd0); // R1
    AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n) chr_valid |=> !chr_valid); // R3
    AST_CHAR_CODE: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_d && ready && plain) |=> (chr_valid && chr_code == $past(bus_wdata[7:0]))); // R3
    AST_LF_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_d && ready && bus_wdata[7:0] == 8'h0A) |=> !chr_valid); // R5
    AST_MOVE_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_d && ready && bus_wdata[7:0] == 8'h07) |=> !chr_valid); // R6
    AST_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (!rst_n) (wr_d && ready) |=> !ready); // R7
    AST_DROP_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_d && !ready) |=> (overrun && !chr_valid)); // R9
    AST_OVR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (overrun && !(wr_c && bus_wdata[1])) |=> overrun); // R9
    AST_OVR_CLEAR: assert property (@(posedge clk) disable iff (!rst_n) (wr_c && bus_wdata[1]) |=> !overrun); // R10
endmodule

bind display_port display_port_chk #(.CTRL_ADDR(CTRL_ADDR), .DATA_ADDR(DATA_ADDR)) u_chk (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .chr_valid(chr_valid), .chr_code(chr_code),
    .ready(ready), .overrun(overrun)
);

// File: tb/display_port_test.sv
`timescale 1ns/1ps
module display_port_test;
    localparam logic [31:0] CTRL = 32'hFFFF_0008;
    localparam logic [31:0] DATA = 32'hFFFF_000C;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic we = 1'b0;
    logic [31:0] addr = '0, wdata = '0;
    logic a_sel = 1'b0, b_sel = 1'b0, a_ack = 1'b0, b_ack = 1'b0;
    logic [31:0] a_rdata, b_rdata;
    logic a_valid, b_valid;
    logic [7:0] a_code, b_code;
    logic [11:0] a_row, a_col, b_row, b_col;
    int checks = 0, errors = 0;

    always #4 clk = ~clk;

    display_port #(.BUSY_CYCLES(3), .WAIT_ACK(1'b0)) uut (
        .clk(clk), .rst_n(rst_n), .bus_sel(a_sel), .bus_we(we), .bus_addr(addr),
        .bus_wdata(wdata), .bus_rdata(a_rdata), .chr_valid(a_valid), .chr_code(a_code),
        .chr_row(a_row), .chr_col(a_col), .chr_ack(a_ack));

    display_port #(.BUSY_CYCLES(2), .WAIT_ACK(1'b1)) uut_ack (
        .clk(clk), .rst_n(rst_n), .bus_sel(b_sel), .bus_we(we), .bus_addr(addr),
        .bus_wdata(wdata), .bus_rdata(b_rdata), .chr_valid(b_valid), .chr_code(b_code),
        .chr_row(b_row), .chr_col(b_col), .chr_ack(b_ack));

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // called at a falling edge; returns one cycle after the write edge
    task automatic wr(input bit to_b, input logic [31:0] a, input logic [31:0] d);
        addr = a; wdata = d; we = 1'b1;
        if (to_b) b_sel = 1'b1; else a_sel = 1'b1;
        @(negedge clk);
        a_sel = 1'b0; b_sel = 1'b0; we = 1'b0;
    endtask

    task automatic rd(input bit to_b, input logic [31:0] a, output logic [31:0] d);
        addr = a; we = 1'b0;
        if (to_b) b_sel = 1'b1; else a_sel = 1'b1;
        #1;
        d = to_b ? b_rdata : a_rdata;
        a_sel = 1'b0; b_sel = 1'b0;
    endtask

    task automatic busy_len(input bit to_b, output int n);
        logic [31:0] v;
        n = 0;
        for (int i = 0; i < 50; i++) begin
            rd(to_b, CTRL, v);
            if (v[0]) break;
            n++;
            @(negedge clk);
        end
    endtask

    task automatic expect_char(input string req, input logic [7:0] c, input int r, input int col);
        check(req, {31'd0, a_valid}, 32'd1);
        check(req, {24'd0, a_code}, {24'd0, c});
        check(req, {20'd0, a_row}, r);
        check(req, {20'd0, a_col}, col);
    endtask

    task automatic t_reset;
        logic [31:0] v;
        rd(1'b0, CTRL, v);
        check("R2 ctrl after reset", v, 32'h1);
        check("R2 strobe idle", {31'd0, a_valid}, 32'd0);
        rd(1'b0, DATA, v);
        check("R1 data read zero", v, 32'd0);
        @(negedge clk);
    endtask

    task automatic t_chars;
        int n;
        wr(1'b0, DATA, 32'hABCD_E041);
        expect_char("R3 first char upper bits ignored", 8'h41, 0, 0);
        busy_len(1'b0, n);
        check("R7 busy length", n, 3);
        wr(1'b0, DATA, 32'h0000_0042);
        expect_char("R4 column advance", 8'h42, 0, 1);
        busy_len(1'b0, n);
    endtask

    task automatic t_linefeed;
        int n;
        wr(1'b0, DATA, 32'h0000_000A);
        check("R5 no strobe on LF", {31'd0, a_valid}, 32'd0);
        busy_len(1'b0, n);
        check("R7 busy after LF", n, 3);
        wr(1'b0, DATA, 32'h0000_0043);
        expect_char("R5 next row start", 8'h43, 1, 0);
        busy_len(1'b0, n);
    endtask

    task automatic t_move;
        int n;
        wr(1'b0, DATA, {12'd700, 12'd33, 8'h07});
        check("R6 no strobe on move", {31'd0, a_valid}, 32'd0);
        busy_len(1'b0, n);
        wr(1'b0, DATA, 32'h44);
        expect_char("R6 moved position", 8'h44, 33, 700);
        busy_len(1'b0, n);
        wr(1'b0, DATA, {12'd4095, 12'd5, 8'h07});
        busy_len(1'b0, n);
        wr(1'b0, DATA, 32'h45);
        expect_char("R4 last column", 8'h45, 5, 4095);
        busy_len(1'b0, n);
        wr(1'b0, DATA, 32'h46);
        expect_char("R4 column wrap", 8'h46, 5, 0);
        busy_len(1'b0, n);
    endtask

    task automatic t_overrun;
        int n;
        logic [31:0] v;
        wr(1'b0, DATA, 32'h47);
        wr(1'b0, DATA, 32'h48);
        check("R9 dropped write no strobe", {31'd0, a_valid}, 32'd0);
        busy_len(1'b0, n);
        rd(1'b0, CTRL, v);
        check("R9 overrun set", v, 32'h3);
        @(negedge clk);
        wr(1'b0, DATA, 32'h49);
        expect_char("R9 cursor unchanged by drop", 8'h49, 5, 2);
        busy_len(1'b0, n);
        rd(1'b0, CTRL, v);
        check("R9 overrun sticky", v, 32'h3);
        @(negedge clk);
        wr(1'b0, CTRL, 32'hFFFF_FFFD);
        rd(1'b0, CTRL, v);
        check("R10 bit1 clear keeps overrun", v, 32'h3);
        @(negedge clk);
        wr(1'b0, CTRL, 32'h2);
        rd(1'b0, CTRL, v);
        check("R10 overrun cleared", v, 32'h1);
        @(negedge clk);
        wr(1'b0, 32'hFFFF_0010, 32'h5A);
        check("R10 stray write no strobe", {31'd0, a_valid}, 32'd0);
        rd(1'b0, CTRL, v);
        check("R10 stray write not busy", v, 32'h1);
        rd(1'b0, 32'hFFFF_0010, v);
        check("R1 other address reads zero", v, 32'd0);
        @(negedge clk);
    endtask

    task automatic t_ack;
        int n;
        logic [31:0] v;
        wr(1'b1, DATA, 32'h61);
        check("R8 strobe in ack mode", {31'd0, b_valid}, 32'd1);
        check("R8 code in ack mode", {24'd0, b_code}, 32'h61);
        for (int i = 0; i < 10; i++) @(negedge clk);
        rd(1'b1, CTRL, v);
        check("R8 held busy without ack", v, 32'h0);
        b_ack = 1'b1;
        @(negedge clk);
        b_ack = 1'b0;
        rd(1'b1, CTRL, v);
        check("R8 ready after ack", v, 32'h1);
        @(negedge clk);
        b_ack = 1'b1;
        @(negedge clk);
        b_ack = 1'b0;
        wr(1'b1, DATA, 32'h62);
        check("R8 idle ack ignored col", {20'd0, b_col}, 32'd1);
        busy_len(1'b1, n);
        check("R8 early ack no effect", n, 50);
        b_ack = 1'b1;
        @(negedge clk);
        b_ack = 1'b0;
        wr(1'b1, DATA, 32'h0A);
        busy_len(1'b1, n);
        check("R7 ack mode LF counted", n, 2);
    endtask

    initial begin
        #5000000;
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_chars();
        t_linefeed();
        t_move();
        t_overrun();
        t_ack();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule